// File: doc/BRIEF.md
# Multiplexer-Tree Thermometer-to-Binary Decoder

This block turns the thermometer word produced by the comparator bank of a flash converter into an N-bit binary result. It does not count ones and does not use a lookup table. It resolves the result one bit at a time, starting from the most significant bit. The current scale is split at its middle tap. The tap value is the bit being decoded. That bit then steers a bank of 2-to-1 multiplexers, which pass on either the lower half or the upper half of the scale. Each half is half the width of the scale it came from. The same step repeats on the chosen half until a single tap is left, and that tap is the least significant bit.

The tree is purely combinational. Its result is captured once into an output register on a rising clock edge when the input strobe is high, and an output strobe follows the input strobe one cycle later. Comparator circuits, gain stages and bubble correction are outside this block. An input that is not a clean thermometer code decodes to whatever the selection tree produces.

Top module: `therm_mux_decoder`

## Requirements
- R1: Tap i of the scale (i = 1 .. 2^BITS−1) sits at bit i−1 of `therm_in`. A clean code whose taps 1..k are one and all others zero decodes to the value k, for every k from 0 to 2^BITS−1.
- R2: The all-zero word decodes to 0, and the all-ones word decodes to 2^BITS−1.
- R3: For any input, bit BITS−1 of the result equals tap 2^(BITS−1), which is bit 2^(BITS−1)−1 of `therm_in`.
- R4: For any input, including inputs with bubbles, the lower bits follow the tree. Start with the scale `therm_in` and a base of 0. At each step, the current bit is the middle element of the current scale. If that bit is 1, the next scale is the elements above the middle and the base moves past the middle. If the bit is 0, the next scale is the elements below the middle. The last single element gives bit 0.
- R5: The result is captured on a rising clock edge where `in_vld` is high, and it appears on `bin_out` from that edge onward (one cycle of latency).
- R6: `out_vld` is high in exactly the cycle after each cycle where `in_vld` was high, and low otherwise.
- R7: While `in_vld` is low, `bin_out` keeps its last value whatever `therm_in` does.
- R8: A synchronous active-high `rst` clears `bin_out` to 0 and `out_vld` to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe; the word on `therm_in` is taken this cycle |
| therm_in | input | 2^BITS−1 | Thermometer taps, tap i at bit i−1 |
| out_vld | output | 1 | High one cycle after a taken input |
| bin_out | output | BITS | Registered binary result |

## Verification
The hardest behaviour to reach is the one the decoder shows on broken codes. With a bubble, the multiplexer steering sends later bits into a partial scale that a ones count would never pick, so the two methods disagree. With the default fifteen taps there are only 32768 possible words. The stimulus therefore applies every one of them, clean or not, and compares each result with a bit-level model of the split-and-select walk. It also checks the sixteen clean codes against their tap count.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    localparam int unsigned DEF_BITS = 4;

    // Which half of a partial scale the multiplexer bank passes on.
    typedef enum logic {
        SCALE_LOWER = 1'b0,
        SCALE_UPPER = 1'b1
    } half_sel_e;

    // Number of taps for a scale that resolves `bits` binary bits.
    function automatic int unsigned scale_width(input int unsigned bits);
        return (32'd1 << bits) - 32'd1;
    endfunction

    // Zero-based position of the middle tap of a scale of `width` taps.
    function automatic int unsigned mid_index(input int unsigned width);
        return (width - 32'd1) / 32'd2;
    endfunction

endpackage

// File: rtl/tdec_split_stage.sv
module tdec_split_stage
    import tdec_pkg::*;
#(
    parameter int unsigned WIDTH = 15
) (
    input  logic [WIDTH-1:0]              scale_in,
    output logic                          bit_out,
    output logic [mid_index(WIDTH)-1:0]   scale_out
);
    localparam int unsigned MID  = mid_index(WIDTH);
    localparam int unsigned HALF = MID;

    half_sel_e sel;

    always_comb begin
        bit_out = scale_in[MID];
        sel     = half_sel_e'(scale_in[MID]);
    end

    // One 2-to-1 multiplexer per tap of the half-size scale.
    for (genvar k = 0; k < HALF; k++) begin : g_mux
        assign scale_out[k] = (sel == SCALE_UPPER) ? scale_in[MID + 1 + k]
                                                   : scale_in[k];
    end

endmodule

// File: rtl/tdec_tree.sv
module tdec_tree
    import tdec_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic [scale_width(BITS)-1:0] therm,
    output logic [BITS-1:0]              bin
);
    // Level j holds the partial scale that resolves bit BITS-1-j.
    for (genvar j = 0; j < BITS; j++) begin : g_lvl
        localparam int unsigned W = scale_width(BITS - j);
        logic [W-1:0] sc;
        if (j == 0) begin : g_root
            assign sc = therm;
        end else begin : g_step
            tdec_split_stage #(
                .WIDTH (scale_width(BITS - j + 1))
            ) u_stage (
                .scale_in  (g_lvl[j-1].sc),
                .bit_out   (bin[BITS - j]),
                .scale_out (sc)
            );
        end
    end

    assign bin[0] = g_lvl[BITS-1].sc[0];

endmodule

// File: rtl/tdec_out_reg.sv
module tdec_out_reg #(
    parameter int unsigned BITS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [BITS-1:0] d,
    output logic            vld_q,
    output logic [BITS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            q     <= '0;
        end else begin
            vld_q <= take;
            if (take) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/therm_mux_decoder.sv
module therm_mux_decoder
    import tdec_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic [scale_width(BITS)-1:0] therm_in,
    output logic                         out_vld,
    output logic [BITS-1:0]              bin_out
);
    logic [BITS-1:0] tree_bin;

    tdec_tree #(
        .BITS (BITS)
    ) u_tree (
        .therm (therm_in),
        .bin   (tree_bin)
    );

    tdec_out_reg #(
        .BITS (BITS)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .take  (in_vld),
        .d     (tree_bin),
        .vld_q (out_vld),
        .q     (bin_out)
    );

endmodule

// File: rtl/tdec_checker.sv
module tdec_checker
    import tdec_pkg::*;
#(
    parameter int unsigned BITS = DEF_BITS
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_vld,
    input logic [scale_width(BITS)-1:0] therm_in,
    input logic                         out_vld,
    input logic [BITS-1:0]              bin_out
);
    localparam int unsigned TAPS = scale_width(BITS);
    localparam int unsigned MID  = mid_index(TAPS);

    logic [TAPS:0] bumped;
    logic          clean_code;

    always_comb begin
        bumped     = {1'b0, therm_in} + {{TAPS{1'b0}}, 1'b1};
        clean_code = ((bumped[TAPS-1:0] & therm_in) == '0);
    end

    // R1: clean codes decode to their tap count
    p_clean_count_r1: assert property (@(posedge clk) disable iff (rst)
        (in_vld && clean_code) |=> (int'(bin_out) == $past($countones(therm_in))));

    // R2: extremes
    p_all_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && therm_in == '0) |=> (bin_out == '0));
    p_all_one_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && therm_in == '1) |=> (bin_out == '1));

    // R3: top bit is the middle tap
    p_msb_mid_r3: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (bin_out[BITS-1] == $past(therm_in[MID])));

    // R6: output strobe follows input strobe
    p_vld_rise_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    p_vld_low_r6: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R7: result holds while no input is taken
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(bin_out));

endmodule

bind therm_mux_decoder tdec_checker #(
    .BITS (BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .therm_in (therm_in),
    .out_vld  (out_vld),
    .bin_out  (bin_out)
);

// File: tb/sim_therm_mux_decoder.sv
module sim_therm_mux_decoder;
    localparam int unsigned BITS   = 4;
    localparam int unsigned TAPS   = (1 << BITS) - 1;
    localparam int          PERIOD = 10;
    localparam int          LIMIT  = 200000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [TAPS-1:0] therm_in = '0;
    logic            out_vld;
    logic [BITS-1:0] bin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    therm_mux_decoder #(.BITS(BITS)) u0 (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .therm_in (therm_in),
        .out_vld  (out_vld),
        .bin_out  (bin_out)
    );

    always #(PERIOD/2) clk = ~clk;

    // Bit-level walk of the split-and-select tree, from the requirement text.
    function automatic int walk(input logic [TAPS-1:0] t);
        int base = 0;
        int w    = TAPS;
        int res  = 0;
        for (int b = BITS - 1; b >= 0; b--) begin
            int mid = base + (w - 1) / 2;
            if (t[mid]) begin
                res  = res | (1 << b);
                base = mid + 1;
            end
            w = (w - 1) / 2;
        end
        return res;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [TAPS-1:0] v);
        @(negedge clk);
        therm_in = v;
        in_vld   = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * LIMIT);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [BITS-1:0] held;
        repeat (3) @(negedge clk);
        chk("R8 reset out_vld", int'(out_vld), 0);
        chk("R8 reset bin_out", int'(bin_out), 0);
        rst = 1'b0;

        // R1: every clean code
        for (int k = 0; k <= TAPS; k++) begin
            apply(TAPS'((32'd1 << k) - 32'd1));
            chk("R1 clean code", int'(bin_out), k);
            chk("R6 strobe follows", int'(out_vld), 1);
        end

        // R2: extremes
        apply('0);
        chk("R2 all zero", int'(bin_out), 0);
        apply('1);
        chk("R2 all ones", int'(bin_out), TAPS);

        // R3, R4, R5: exhaustive sweep of every input word
        for (int v = 0; v < (1 << TAPS); v++) begin
            apply(TAPS'(v));
            chk("R4 tree walk", int'(bin_out), walk(TAPS'(v)));
            chk("R3 msb middle tap", int'(bin_out[BITS-1]), int'(v[TAPS/2]));
        end

        // R5: result appears only after the capturing edge
        @(negedge clk);
        therm_in = '0;
        in_vld   = 1'b1;
        @(negedge clk);
        in_vld   = 1'b0;
        therm_in = 15'h00ff;
        chk("R5 captured value", int'(bin_out), 0);
        @(negedge clk);
        chk("R6 strobe drops", int'(out_vld), 0);

        // R7: hold while strobe low, with a changing input
        apply(15'h003f);
        held = bin_out;
        chk("R7 base value", int'(held), 6);
        @(negedge clk);
        in_vld = 1'b0;
        therm_in = 15'h7fff;
        @(negedge clk);
        therm_in = 15'h5a5a;
        @(negedge clk);
        chk("R7 hold", int'(bin_out), int'(held));
        chk("R6 idle strobe", int'(out_vld), 0);

        // R8: reset in mid-run
        apply(15'h07ff);
        chk("R8 before reset", int'(bin_out), 11);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 clear bin_out", int'(bin_out), 0);
        chk("R8 clear out_vld", int'(out_vld), 0);
        rst    = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule